// File: doc/BRIEF.md
# Windowed Frame-Buffer Write Address Generator

This block turns a stream of 12-bit colour pixels into RAM writes for a 132 x 132 frame buffer. Software programs a rectangular window (column start and end, row start and end) and a mode word. Each accepted pixel is written at the current pointer, and the pointer then steps through the window. It moves along a row first when the vertical flag is clear and down a column first when the flag is set. After the last cell of the window it returns to the window origin.

Two mirror flags reflect the column and the row address on their way to the RAM. The pointer itself keeps counting in logical coordinates. A small arbiter shares the single RAM port with a display read path. Pixel writes always take the port. A read that collides with a write is held and issued in the first cycle without a write.

Top module: `fb_win_writer`

## Requirements
- R1: Every address the block puts on the RAM port lies in 0..131. A window value written above 131 is stored as 131, and a pointer that reaches 131 treats it as the end of its axis.
- R2: Each cycle with `pix_valid` high produces exactly one RAM write (`ram_en`=1, `ram_we`=1) on the next clock, carrying `pix_data` unchanged on `ram_wdata`.
- R3: With mode bit 0 clear, the column advances by one per pixel. At the column end it reloads the column start and the row advances.
- R4: With mode bit 0 set, the row advances by one per pixel. At the row end it reloads the row start and the column advances.
- R5: After the pixel at (column end, row end), the next pixel goes to (column start, row start).
- R6: Mode bit 1 makes the RAM column 131 minus the logical column. Mode bit 2 does the same for the row. The two act independently.
- R7: `cfg_sel` picks the target of a `cfg_we` write: 0 column start, 1 column end, 2 row start, 3 row end, 4 mode. Any configuration write, or a `start` pulse, returns the pointer to (column start, row start).
- R8: A pixel write wins over a read request in the same cycle. The read is then issued, unmirrored, on the first clock with no pixel. A read with no competing pixel is issued on the next clock.
- R9: `rd_valid` rises two clocks after the read command appears on the RAM port. It carries the word the RAM returned one clock after that command.
- R10: After reset, the RAM port is idle, the window covers 0..131 on both axes, the mode is 0 and the pointer is (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target select |
| cfg_val | input | 8 | Configuration value |
| start | input | 1 | Return pointer to window origin |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 12 | Pixel colour, 4 bits per channel |
| rd_req | input | 1 | Display read request |
| rd_x | input | 8 | Read column |
| rd_y | input | 8 | Read row |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_x | output | 8 | RAM column address |
| ram_y | output | 8 | RAM row address |
| ram_wdata | output | 12 | RAM write data |
| ram_rdata | input | 12 | RAM read data (one clock after read command) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 12 | Returned read data |

## Verification
A pixel or read command driven before an edge shows up on the RAM port right after that edge, one clock of latency. Returned read data follows two clocks after the command is on the port. The bench drives inputs on the falling edge and checks the port at the next falling edge. Read results are checked exactly two falling edges after the command is seen, and the bench also confirms that `rd_valid` is still low one edge earlier. Address expectations come from a stepping model written in the bench from the ordering, wrap and mirror rules.

// File: rtl/fb_win_pkg.sv
package fb_win_pkg;
  typedef enum logic [2:0] {
    SEL_COL_START = 3'd0,
    SEL_COL_END   = 3'd1,
    SEL_ROW_START = 3'd2,
    SEL_ROW_END   = 3'd3,
    SEL_MODE      = 3'd4
  } cfg_sel_e;

  localparam int MODE_BITS = 3;
  localparam int MODE_VERT = 0;
  localparam int MODE_MIRX = 1;
  localparam int MODE_MIRY = 2;
endpackage

// File: rtl/fb_win_ptr.sv
module fb_win_ptr
  import fb_win_pkg::*;
#(
  parameter int DIM = 132,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_val,
  input  logic          start,
  input  logic          step,
  output logic [AW-1:0] cur_x,
  output logic [AW-1:0] cur_y,
  output logic          vert,
  output logic          mir_x,
  output logic          mir_y
);
  localparam logic [AW-1:0] LAST = AW'(DIM - 1);

  logic [AW-1:0] xs_q, xe_q, ys_q, ye_q;
  logic [AW-1:0] xs_n, xe_n, ys_n, ye_n;
  logic [MODE_BITS-1:0] mode_q, mode_n;
  logic [AW-1:0] val_c;
  logic x_end, y_end, reload;

  always_comb begin
    val_c  = (cfg_val > LAST) ? LAST : cfg_val;
    xs_n   = xs_q;
    xe_n   = xe_q;
    ys_n   = ys_q;
    ye_n   = ye_q;
    mode_n = mode_q;
    if (cfg_we) begin
      case (cfg_sel)
        SEL_COL_START: xs_n = val_c;
        SEL_COL_END:   xe_n = val_c;
        SEL_ROW_START: ys_n = val_c;
        SEL_ROW_END:   ye_n = val_c;
        SEL_MODE:      mode_n = cfg_val[MODE_BITS-1:0];
        default: ;
      endcase
    end
  end

  assign reload = cfg_we | start;
  assign x_end  = (cur_x == xe_q) || (cur_x == LAST);
  assign y_end  = (cur_y == ye_q) || (cur_y == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      xs_q   <= '0;
      ys_q   <= '0;
      xe_q   <= LAST;
      ye_q   <= LAST;
      mode_q <= '0;
      cur_x  <= '0;
      cur_y  <= '0;
    end else begin
      xs_q   <= xs_n;
      xe_q   <= xe_n;
      ys_q   <= ys_n;
      ye_q   <= ye_n;
      mode_q <= mode_n;
      if (reload) begin
        cur_x <= xs_n;
        cur_y <= ys_n;
      end else if (step) begin
        if (!mode_q[MODE_VERT]) begin
          if (x_end) begin
            cur_x <= xs_q;
            cur_y <= y_end ? ys_q : cur_y + 1'b1;
          end else begin
            cur_x <= cur_x + 1'b1;
          end
        end else begin
          if (y_end) begin
            cur_y <= ys_q;
            cur_x <= x_end ? xs_q : cur_x + 1'b1;
          end else begin
            cur_y <= cur_y + 1'b1;
          end
        end
      end
    end
  end

  assign vert  = mode_q[MODE_VERT];
  assign mir_x = mode_q[MODE_MIRX];
  assign mir_y = mode_q[MODE_MIRY];

  assert_ptr_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    (cur_x <= LAST) && (cur_y <= LAST));

  assert_reload_origin_R7: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cur_x == xs_q) && (cur_y == ys_q));

  assert_row_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !reload && !vert && !x_end) |=>
      (cur_x == $past(cur_x) + 1'b1) && $stable(cur_y));

  assert_col_step_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !reload && vert && !y_end) |=>
      (cur_y == $past(cur_y) + 1'b1) && $stable(cur_x));

  assert_window_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !reload && x_end && y_end) |=>
      (cur_x == xs_q) && (cur_y == ys_q));
endmodule

// File: rtl/fb_axis_mirror.sv
module fb_axis_mirror #(
  parameter int DIM = 132,
  parameter int AW  = 8
) (
  input  logic          flip,
  input  logic [AW-1:0] logical,
  output logic [AW-1:0] physical
);
  localparam logic [AW-1:0] LAST = AW'(DIM - 1);

  assign physical = flip ? (LAST - logical) : logical;
endmodule

// File: rtl/fb_port_arb.sv
module fb_port_arb #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_x,
  input  logic [AW-1:0] wr_y,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_x,
  input  logic [AW-1:0] rd_y,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_x,
  output logic [AW-1:0] ram_y,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic          pend_q;
  logic [AW-1:0] pend_x, pend_y;
  logic          ret_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en    <= 1'b0;
      ram_we    <= 1'b0;
      ram_x     <= '0;
      ram_y     <= '0;
      ram_wdata <= '0;
      pend_q    <= 1'b0;
      pend_x    <= '0;
      pend_y    <= '0;
      ret_q     <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (wr_req) begin
        ram_en    <= 1'b1;
        ram_we    <= 1'b1;
        ram_x     <= wr_x;
        ram_y     <= wr_y;
        ram_wdata <= wr_data;
        if (rd_req) begin
          pend_q <= 1'b1;
          pend_x <= rd_x;
          pend_y <= rd_y;
        end
      end else if (rd_req || pend_q) begin
        ram_en <= 1'b1;
        ram_we <= 1'b0;
        ram_x  <= rd_req ? rd_x : pend_x;
        ram_y  <= rd_req ? rd_y : pend_y;
        pend_q <= 1'b0;
      end else begin
        ram_en <= 1'b0;
        ram_we <= 1'b0;
      end
      ret_q    <= ram_en && !ram_we;
      rd_valid <= ret_q;
      if (ret_q) rd_data <= ram_rdata;
    end
  end

  assert_one_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> ram_en && ram_we && (ram_wdata == $past(wr_data)));

  assert_no_stray_write_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_req |=> !ram_we);

  assert_read_now_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_req) |=> ram_en && !ram_we && (ram_x == $past(rd_x)));

  assert_deferred_read_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !wr_req) |=> ram_en && !ram_we);

  assert_read_return_R9: assert property (@(posedge clk) disable iff (rst)
    (ram_en && !ram_we) |=> ##1 rd_valid);
endmodule

// File: rtl/fb_win_writer.sv
module fb_win_writer #(
  parameter int DIM = 132,
  parameter int AW  = 8,
  parameter int DW  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_val,
  input  logic          start,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_x,
  input  logic [AW-1:0] rd_y,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_x,
  output logic [AW-1:0] ram_y,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [AW-1:0] lx, ly, px, py;
  logic          vert, mir_x, mir_y;

  fb_win_ptr #(.DIM(DIM), .AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_val(cfg_val), .start(start), .step(pix_valid),
    .cur_x(lx), .cur_y(ly), .vert(vert), .mir_x(mir_x), .mir_y(mir_y)
  );

  fb_axis_mirror #(.DIM(DIM), .AW(AW)) u_mir_x (
    .flip(mir_x), .logical(lx), .physical(px)
  );

  fb_axis_mirror #(.DIM(DIM), .AW(AW)) u_mir_y (
    .flip(mir_y), .logical(ly), .physical(py)
  );

  fb_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst(rst),
    .wr_req(pix_valid), .wr_x(px), .wr_y(py), .wr_data(pix_data),
    .rd_req(rd_req), .rd_x(rd_x), .rd_y(rd_y),
    .ram_en(ram_en), .ram_we(ram_we), .ram_x(ram_x), .ram_y(ram_y),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  localparam logic [AW-1:0] LAST = AW'(DIM - 1);

  assert_port_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    ram_en |-> (ram_x <= LAST) && (ram_y <= LAST));

  assert_mirror_pair_R6: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && mir_x) |=> (ram_x == LAST - $past(lx)));
endmodule

// File: tb/fb_win_writer_tb.sv
module fb_win_writer_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = 0;
  logic [7:0]  cfg_val = 0;
  logic        start = 0;
  logic        pix_valid = 0;
  logic [11:0] pix_data = 0;
  logic        rd_req = 0;
  logic [7:0]  rd_x = 0, rd_y = 0;
  logic        ram_en, ram_we, rd_valid;
  logic [7:0]  ram_x, ram_y;
  logic [11:0] ram_wdata, rd_data;
  logic [11:0] ram_rdata = 0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  fb_win_writer u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .start(start), .pix_valid(pix_valid), .pix_data(pix_data),
    .rd_req(rd_req), .rd_x(rd_x), .rd_y(rd_y),
    .ram_en(ram_en), .ram_we(ram_we), .ram_x(ram_x), .ram_y(ram_y),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk)
    if (ram_en && !ram_we) ram_rdata <= {ram_x[5:0], ram_y[5:0]};

  // mode(3) xs xe ys ye count
  localparam logic [42:0] VEC [12] = '{
    {3'd0, 8'd2,   8'd5,   8'd1,   8'd3,   8'd15},
    {3'd1, 8'd2,   8'd5,   8'd1,   8'd3,   8'd15},
    {3'd2, 8'd0,   8'd3,   8'd0,   8'd2,   8'd14},
    {3'd3, 8'd10,  8'd12,  8'd4,   8'd6,   8'd12},
    {3'd4, 8'd127, 8'd131, 8'd129, 8'd131, 8'd17},
    {3'd5, 8'd127, 8'd131, 8'd129, 8'd131, 8'd17},
    {3'd6, 8'd60,  8'd62,  8'd70,  8'd71,  8'd9},
    {3'd7, 8'd60,  8'd62,  8'd70,  8'd71,  8'd9},
    {3'd0, 8'd20,  8'd30,  8'd8,   8'd8,   8'd14},
    {3'd1, 8'd20,  8'd30,  8'd8,   8'd8,   8'd14},
    {3'd0, 8'd9,   8'd9,   8'd40,  8'd44,  8'd8},
    {3'd1, 8'd9,   8'd9,   8'd40,  8'd44,  8'd8}
  };

  logic [7:0] mx_x, mx_y, m_xs, m_xe, m_ys, m_ye;
  logic [2:0] m_mode;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] s, input logic [7:0] v);
    cfg_we = 1; cfg_sel = s; cfg_val = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic setup(input logic [2:0] mode, input logic [7:0] xs, xe, ys, ye);
    cfg(3'd0, xs); cfg(3'd1, xe); cfg(3'd2, ys); cfg(3'd3, ye); cfg(3'd4, {5'd0, mode});
    m_mode = mode;
    m_xs = (xs > 131) ? 8'd131 : xs; m_xe = (xe > 131) ? 8'd131 : xe;
    m_ys = (ys > 131) ? 8'd131 : ys; m_ye = (ye > 131) ? 8'd131 : ye;
    mx_x = m_xs; mx_y = m_ys;
  endtask

  task automatic model_step();
    bit xe_hit = (mx_x == m_xe) || (mx_x == 8'd131);
    bit ye_hit = (mx_y == m_ye) || (mx_y == 8'd131);
    if (!m_mode[0]) begin
      if (xe_hit) begin mx_x = m_xs; mx_y = ye_hit ? m_ys : mx_y + 1; end
      else mx_x = mx_x + 1;
    end else begin
      if (ye_hit) begin mx_y = m_ys; mx_x = xe_hit ? m_xs : mx_x + 1; end
      else mx_y = mx_y + 1;
    end
  endtask

  task automatic pixels(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] ex = m_mode[1] ? 8'd131 - mx_x : mx_x;
      logic [7:0] ey = m_mode[2] ? 8'd131 - mx_y : mx_y;
      logic [11:0] d = 12'(i * 37 + 5);
      pix_valid = 1; pix_data = d;
      @(negedge clk);
      check(ram_en && ram_we, req, "write strobe", {ram_en, ram_we}, 3);
      check(ram_x == ex, req, "column", ram_x, ex);
      check(ram_y == ey, req, "row", ram_y, ey);
      check(ram_wdata == d, "R2", "data", ram_wdata, d);
      model_step();
    end
    pix_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none

    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    check(!ram_en && !ram_we && !rd_valid, "R10", "idle port after reset",
          {ram_en, ram_we, rd_valid}, 0);
    m_mode = 0; m_xs = 0; m_xe = 131; m_ys = 0; m_ye = 131; mx_x = 0; mx_y = 0;
    pixels(134, "R10");  // default full window: row 0 across, then row 1

    // table walk: R3 R4 R5 R6, single-row and single-column windows
    for (int v = 0; v < 12; v++) begin
      setup(VEC[v][42:40], VEC[v][39:32], VEC[v][31:24], VEC[v][23:16], VEC[v][15:8]);
      pixels(int'(VEC[v][7:0]), VEC[v][40] ? "R4/R5/R6" : "R3/R5/R6");
    end

    // R1: clamped end value, pointer stops at 131
    setup(3'd0, 8'd129, 8'd200, 8'd5, 8'd5);
    pixels(5, "R1");

    // R7: start pulse returns pointer to origin
    setup(3'd0, 8'd3, 8'd5, 8'd7, 8'd9);
    pixels(2, "R7");
    start = 1; @(negedge clk); start = 0;
    mx_x = m_xs; mx_y = m_ys;
    pixels(2, "R7");
    // R7: config write mid-stream reloads origin
    pixels(1, "R7");
    cfg(3'd3, 8'd9);
    mx_x = m_xs; mx_y = m_ys;
    pixels(1, "R7");

    // R8: read collides with pixel, deferred until idle
    pix_valid = 1; pix_data = 12'h111; rd_req = 1; rd_x = 8'd10; rd_y = 8'd20;
    @(negedge clk);
    rd_req = 0;
    check(ram_en && ram_we, "R8", "write wins", ram_we, 1);
    @(negedge clk);
    pix_valid = 0;
    check(ram_we, "R8", "second write still wins", ram_we, 1);
    @(negedge clk);
    check(ram_en && !ram_we && ram_x == 10 && ram_y == 20, "R8",
          "deferred read on port", {ram_x, ram_y}, {8'd10, 8'd20});
    @(negedge clk);
    check(!rd_valid, "R9", "valid not early", rd_valid, 0);
    @(negedge clk);
    check(rd_valid && rd_data == {6'd10, 6'd20}, "R9", "read return",
          rd_data, {6'd10, 6'd20});

    // R8: uncontested read goes next clock, unmirrored under mirror mode
    setup(3'd6, 8'd0, 8'd131, 8'd0, 8'd131);
    rd_req = 1; rd_x = 8'd33; rd_y = 8'd44;
    @(negedge clk);
    rd_req = 0;
    check(ram_en && !ram_we && ram_x == 33 && ram_y == 44, "R8",
          "immediate read", {ram_x, ram_y}, {8'd33, 8'd44});
    @(negedge clk); @(negedge clk);
    check(rd_valid && rd_data == {6'd33, 6'd44}, "R9", "immediate read return",
          rd_data, {6'd33, 6'd44});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule